// File: doc/BRIEF.md
# Serial Audio Direction Status and Interrupt Control

This block is the control and status register for one direction of a serial audio port, either transmit or receive. It collects event pulses from the serial engine and level indications from the FIFO. It keeps them as readable flags, masks them with per-flag interrupt enables, and drives an interrupt line and a DMA request line. Software reaches everything through one 32-bit register. A write is a single-cycle strobe with data, and the readback is always present on `csr_rdata`.

The same register controls the direction. An enable bit starts the direction. When software clears it, the bit keeps reading as one and the direction keeps running until the serial engine reports the end of the frame in progress. A FIFO flush bit produces a one-cycle pulse toward the FIFO pointers. A soft reset bit holds the direction's status logic idle for as long as it is set, and the configuration bits keep their values. On the transmit side the FIFO error event stands for underrun; on the receive side it stands for overflow. The logic is the same for both.

Top module: `aud_dir_csr`

## Requirements
- R1: After `rst_n` is low, `csr_rdata` is 0 and `irq`, `dma_req`, `fifo_flush`, `dir_run` and `dir_srst` are 0.
- R2: A one-cycle pulse on `evt_fifo_err`, `evt_sync_err` or `evt_word_start` sets flag bit 18, 19 or 20 respectively, and the bit is visible on `csr_rdata` after that clock edge.
- R3: Bits 18, 19 and 20 are cleared by a write with a one in that bit. A zero written there leaves the flag as it was. An event in the same cycle as a clearing write leaves the flag set.
- R4: Bit 16 follows `lvl_fifo_wmark` and bit 17 follows `lvl_fifo_warn`, one clock edge late. Writes to either bit have no effect.
- R5: The interrupt enable for the flag at bit 16+k sits at bit 8+k. `irq` rises one edge after an enabled flag appears in the readback. A flag whose enable is 0 never raises `irq`.
- R6: `dma_req` is 1 exactly when the DMA enable at bit 0 is 1 and watermark flag bit 16 is 1, outside soft reset.
- R7: Writing a one to bit 25 gives a `fifo_flush` pulse one cycle long after that edge. Bit 25 always reads 0.
- R8: Writing a one to bit 31 makes bit 31 and `dir_run` read 1 after the edge. After a write of zero they stay 1 until a `frame_end` pulse arrives in a later cycle, and they clear on that edge. A `frame_end` in the same cycle as the clearing write does not stop the direction.
- R9: While soft reset bit 24 is 1, `dir_srst` is 1, flags 16 to 20 read 0 from the next edge on and ignore events, the direction cannot run, and `irq` and `dma_req` stay 0. Bits 0, 8 to 12 and 24 keep their written values. Writing 0 to bit 24 ends the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register readback |
| evt_word_start | input | 1 | Pulse at the start of a serial word |
| evt_sync_err | input | 1 | Pulse on a frame sync error |
| evt_fifo_err | input | 1 | Pulse on FIFO underrun (transmit) or overflow (receive) |
| lvl_fifo_warn | input | 1 | FIFO empty (transmit) or full (receive) level |
| lvl_fifo_wmark | input | 1 | FIFO watermark reached level |
| frame_end | input | 1 | Pulse at the end of a serial frame |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| fifo_flush | output | 1 | One-cycle FIFO pointer reset |
| dir_run | output | 1 | Direction is active |
| dir_srst | output | 1 | Direction held in soft reset |

## Verification
The key overlap is a write-one-to-clear landing in the same cycle as a new event pulse on the same flag. The bench drives both within one clock and expects the flag to stay set and the interrupt to follow it. The second overlap is a `frame_end` pulse arriving in the same cycle as the write that clears the enable. The bench expects the direction to keep running and stop only on the next `frame_end`. Soft reset is also asserted while events and the watermark level are active, and the bench expects the flags, `irq` and `dma_req` to stay quiet while the enables still read back.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;
    localparam int CSR_W     = 32;
    localparam int NFLAG     = 5;
    localparam int DMAEN_BIT = 0;
    localparam int IE_LSB    = 8;
    localparam int FLAG_LSB  = IE_LSB + 8;
    localparam int SRST_BIT  = 24;
    localparam int FLUSH_BIT = 25;
    localparam int RUN_BIT   = 31;
    // flag index: 0 watermark, 1 warning, 2 fifo error, 3 sync error, 4 word start
    localparam logic [NFLAG-1:0] STICKY_MASK = 5'b11100;

    typedef struct packed {
        logic [NFLAG-1:0] ie;
        logic             dma_en;
        logic             srst;
        logic             flush;
        logic             irq;
    } ctl_t;

    typedef struct packed {
        logic run;
        logic en_req;
    } run_t;
endpackage

// File: rtl/aud_csr_flag.sv
module aud_csr_flag #(
    parameter bit STICKY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic evt,
    input  logic wr_clr,
    output logic flag_o
);
    logic flag_d, flag_q;

    generate
        if (STICKY) begin : g_sticky
            always_comb begin
                flag_d = (flag_q & ~wr_clr) | evt;
                if (hold) flag_d = 1'b0;
            end
        end else begin : g_level
            logic unused_clr;
            assign unused_clr = wr_clr;
            always_comb begin
                flag_d = evt;
                if (hold) flag_d = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/aud_csr_run.sv
module aud_csr_run
    import aud_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic wr,
    input  logic wr_run,
    input  logic frame_end,
    output logic run_o
);
    run_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.en_req = wr_run;
        if (wr && wr_run) begin
            st_d.run = 1'b1;
        end else if (st_q.run && !st_q.en_req && frame_end) begin
            st_d.run = 1'b0;
        end
        if (srst) begin
            st_d.run    = 1'b0;
            st_d.en_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;
endmodule

// File: rtl/aud_dir_csr.sv
module aud_dir_csr
    import aud_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             evt_word_start,
    input  logic             evt_sync_err,
    input  logic             evt_fifo_err,
    input  logic             lvl_fifo_warn,
    input  logic             lvl_fifo_wmark,
    input  logic             frame_end,
    output logic             irq,
    output logic             dma_req,
    output logic             fifo_flush,
    output logic             dir_run,
    output logic             dir_srst
);
    ctl_t             ctl_d, ctl_q;
    logic [NFLAG-1:0] evt_vec, clr_vec, flags;
    logic             run;
    logic             unused_wdata;

    assign unused_wdata = ^csr_wdata;
    assign evt_vec = {evt_word_start, evt_sync_err, evt_fifo_err,
                      lvl_fifo_warn, lvl_fifo_wmark};
    assign clr_vec = csr_wr ? csr_wdata[FLAG_LSB +: NFLAG] : '0;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            aud_csr_flag #(.STICKY(STICKY_MASK[i])) u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .hold   (ctl_q.srst),
                .evt    (evt_vec[i]),
                .wr_clr (clr_vec[i]),
                .flag_o (flags[i])
            );
        end
    endgenerate

    aud_csr_run u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (ctl_q.srst),
        .wr        (csr_wr),
        .wr_run    (csr_wdata[RUN_BIT]),
        .frame_end (frame_end),
        .run_o     (run)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.flush = 1'b0;
        if (csr_wr) begin
            ctl_d.ie     = csr_wdata[IE_LSB +: NFLAG];
            ctl_d.dma_en = csr_wdata[DMAEN_BIT];
            ctl_d.srst   = csr_wdata[SRST_BIT];
            ctl_d.flush  = csr_wdata[FLUSH_BIT];
        end
        ctl_d.irq = !ctl_q.srst && |(flags & ctl_q.ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        csr_rdata                        = '0;
        csr_rdata[DMAEN_BIT]             = ctl_q.dma_en;
        csr_rdata[IE_LSB +: NFLAG]       = ctl_q.ie;
        csr_rdata[FLAG_LSB +: NFLAG]     = flags;
        csr_rdata[SRST_BIT]              = ctl_q.srst;
        csr_rdata[RUN_BIT]               = run;
    end

    assign irq        = ctl_q.irq;
    assign dma_req    = ctl_q.dma_en && flags[0] && !ctl_q.srst;
    assign fifo_flush = ctl_q.flush;
    assign dir_run    = run;
    assign dir_srst   = ctl_q.srst;
endmodule

// File: rtl/aud_dir_csr_chk.sv
module aud_dir_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_wr,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata,
    input logic        frame_end,
    input logic        irq,
    input logic        dma_req,
    input logic        fifo_flush,
    input logic        dir_run,
    input logic        dir_srst
);
    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !fifo_flush); // R7
    AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[25]); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[12:8] == 5'd0) |=> !irq); // R5
    AST_DMA_NEEDS_WMARK: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (csr_rdata[16] && csr_rdata[0])); // R6
    AST_RUN_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir_run) |-> ($past(frame_end) || $past(dir_srst))); // R8
    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dir_srst |=> (!irq && !dma_req && !dir_run)); // R9
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_rdata[19]) |-> ($past(csr_wr && csr_wdata[19]) || $past(dir_srst))); // R3
endmodule

bind aud_dir_csr aud_dir_csr_chk u_chk (.*);

// File: tb/aud_dir_csr_bench.sv
module aud_dir_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        evt_word_start = 1'b0, evt_sync_err = 1'b0, evt_fifo_err = 1'b0;
    logic        lvl_fifo_warn = 1'b0, lvl_fifo_wmark = 1'b0, frame_end = 1'b0;
    logic        irq, dma_req, fifo_flush, dir_run, dir_srst;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    aud_dir_csr u_aud_dir_csr (.*);

    // {wr, wdata, evt{wstart,serr,ferr}, lvl{warn,wmark}, exp_rdata, exp_irq, exp_dma}
    localparam logic [71:0] TBL [0:16] = '{
        {1'b1, 32'h00001F01, 3'b000, 2'b00, 32'h00001F01, 1'b0, 1'b0},
        {1'b0, 32'h00000000, 3'b100, 2'b00, 32'h00101F01, 1'b0, 1'b0},
        {1'b0, 32'h00000000, 3'b000, 2'b00, 32'h00101F01, 1'b1, 1'b0},
        {1'b1, 32'h00101F01, 3'b000, 2'b00, 32'h00001F01, 1'b1, 1'b0},
        {1'b0, 32'h00000000, 3'b000, 2'b00, 32'h00001F01, 1'b0, 1'b0},
        {1'b0, 32'h00000000, 3'b000, 2'b01, 32'h00011F01, 1'b0, 1'b1},
        {1'b1, 32'h00011F01, 3'b000, 2'b01, 32'h00011F01, 1'b1, 1'b1},
        {1'b0, 32'h00000000, 3'b000, 2'b00, 32'h00001F01, 1'b1, 1'b0},
        {1'b1, 32'h00000000, 3'b010, 2'b00, 32'h00080000, 1'b0, 1'b0},
        {1'b0, 32'h00000000, 3'b000, 2'b00, 32'h00080000, 1'b0, 1'b0},
        {1'b1, 32'h00000800, 3'b000, 2'b00, 32'h00080800, 1'b0, 1'b0},
        {1'b0, 32'h00000000, 3'b000, 2'b00, 32'h00080800, 1'b1, 1'b0},
        {1'b1, 32'h00080800, 3'b010, 2'b00, 32'h00080800, 1'b1, 1'b0},
        {1'b1, 32'h00080800, 3'b000, 2'b00, 32'h00000800, 1'b1, 1'b0},
        {1'b0, 32'h00000000, 3'b000, 2'b00, 32'h00000800, 1'b0, 1'b0},
        {1'b0, 32'h00000000, 3'b001, 2'b10, 32'h00060800, 1'b0, 1'b0},
        {1'b1, 32'h00060000, 3'b000, 2'b10, 32'h00020000, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0; frame_end = 1'b0;
        evt_word_start = 1'b0; evt_sync_err = 1'b0; evt_fifo_err = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        csr_wr = 1'b1; csr_wdata = d;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", csr_rdata, 32'h0);
        chk("R1 outputs in reset", {27'd0, irq, dma_req, fifo_flush, dir_run, dir_srst}, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 rdata after reset", csr_rdata, 32'h0);

        for (int i = 0; i < 17; i++) begin
            csr_wr         = TBL[i][71];
            csr_wdata      = TBL[i][70:39];
            evt_word_start = TBL[i][38];
            evt_sync_err   = TBL[i][37];
            evt_fifo_err   = TBL[i][36];
            lvl_fifo_warn  = TBL[i][35];
            lvl_fifo_wmark = TBL[i][34];
            step();
            chk($sformatf("R2 R3 R4 row %0d rdata", i), csr_rdata, TBL[i][33:2]);
            chk($sformatf("R5 row %0d irq", i), {31'd0, irq}, {31'd0, TBL[i][1]});
            chk($sformatf("R6 row %0d dma_req", i), {31'd0, dma_req}, {31'd0, TBL[i][0]});
        end
        lvl_fifo_warn = 1'b0;
        wr(32'h00040000);
        step();
        chk("R3 clear leftover", csr_rdata, 32'h0);

        // FIFO flush strobe
        wr(32'h02000000);
        step();
        chk("R7 flush pulse", {31'd0, fifo_flush}, 32'd1);
        chk("R7 flush reads zero", csr_rdata, 32'h0);
        step();
        chk("R7 flush ends", {31'd0, fifo_flush}, 32'd0);

        // enable and drain
        wr(32'h80000000);
        step();
        chk("R8 run set", {csr_rdata[31], dir_run}, 32'd3);
        frame_end = 1'b1;
        step();
        chk("R8 frame end while enabled", {31'd0, dir_run}, 32'd1);
        wr(32'h0);
        step();
        chk("R8 reads one after clear", {31'd0, csr_rdata[31]}, 32'd1);
        step(); step();
        chk("R8 still draining", {31'd0, dir_run}, 32'd1);
        frame_end = 1'b1;
        step();
        chk("R8 stop at frame end", {csr_rdata[31], dir_run}, 32'd0);
        wr(32'h80000000);
        step();
        wr(32'h0); frame_end = 1'b1;
        step();
        chk("R8 frame end with clearing write", {31'd0, dir_run}, 32'd1);
        frame_end = 1'b1;
        step();
        chk("R8 stop on later frame end", {31'd0, dir_run}, 32'd0);

        // soft reset
        wr(32'h00001F01); lvl_fifo_wmark = 1'b1; evt_word_start = 1'b1;
        step();
        chk("R9 flags before reset", csr_rdata, 32'h00111F01);
        wr(32'h01001F01);
        step();
        evt_word_start = 1'b1; evt_sync_err = 1'b1;
        step();
        chk("R9 rdata in soft reset", csr_rdata, 32'h01001F01);
        chk("R9 quiet outputs", {29'd0, irq, dma_req, dir_srst}, 32'd1);
        wr(32'h81001F01);
        step();
        chk("R9 run blocked", {31'd0, dir_run}, 32'd0);
        wr(32'h00001F01);
        step();
        step();
        chk("R9 released", csr_rdata, 32'h00011F01);
        chk("R6 dma after release", {31'd0, dma_req}, 32'd1);
        lvl_fifo_wmark = 1'b0;
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule